// File: doc/BRIEF.md
# Dual-Enable Static Word Memory

This block is a synthesizable replacement for a small asynchronous static memory that has a shared bidirectional data bus. The bus is split into three signals: a data input, a registered data output and an output-drive enable. A pad ring or a bus multiplexer above the block combines them. Two active-low chip selects must both be low before the array responds. An active-low write strobe and an active-low output enable then pick one of four modes: standby, output inhibit, read or write.

All controls, the address and the input data are sampled on a fast internal clock. A write commits on the sampling edge where the write strobe and both chip selects are low. Read data and the drive enable appear one clock after the sampling edge that saw the read condition. The write strobe overrides the output enable, so the drive enable is never raised during a write.

The default word count is kept small so that the block elaborates quickly. The full 16K x 4 organisation is obtained with `ADDR_W = 14` and `DATA_W = 4`. Memory contents are not initialised by reset.

Top module: `sramTop`

## Requirements
- R1: While `rstN` is low, and at the first sample after it is released with the chip deselected, `dOutEn` is 0 and `dOut` is 0.
- R2: At an edge where `ce1N` or `ce2N` is 1, nothing is written, whatever `weN` and `oeN` are, and `dOutEn` is 0 after that edge.
- R3: At an edge with both chip selects 0, `weN` = 1 and `oeN` = 1 (output inhibit), `dOutEn` is 0 after that edge and nothing is written.
- R4: At an edge with both chip selects 0, `weN` = 1 and `oeN` = 0 (read), `dOutEn` is 1 after that edge and `dOut` holds the word stored at the sampled address.
- R5: At an edge with both chip selects 0 and `weN` = 0, `dIn` is stored at `addr` for either value of `oeN`, and `dOutEn` is 0 after that edge.
- R6: `dOut` is 0 whenever `dOutEn` is 0.
- R7: A read sampled on the edge right after a write to the same address returns the newly written word.
- R8: When a chip select and `weN` both rise at the same edge, `dOutEn` stays 0 after that edge, and the write committed on the previous edge is kept.
- R9: Every one of the 2^`ADDR_W` words holds its own value, independent of writes to other addresses.
- R10: Reads on consecutive edges at changing addresses return each addressed word in turn, one clock after each sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Active-low reset of the output registers |
| addr | input | ADDR_W | Word address |
| ce1N | input | 1 | First chip select, active low |
| ce2N | input | 1 | Second chip select, active low |
| weN | input | 1 | Write strobe, active low; overrides the output enable |
| oeN | input | 1 | Output enable, active low |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Registered read data, 0 when not driving |
| dOutEn | output | 1 | Bus drive enable, high only after a valid read sample |

## Verification
Two pairs of functions meet across adjacent edges. In the first, a write on one edge is followed by a read of the same word on the next edge. The bench sweeps this over every address of a 64-word instance and expects the fresh word back. In the second, a chip select and the write strobe rise on the same edge; the bench expects the drive enable to stay low and then reads back the word written on the edge before. Both checks compare against a data pattern computed from the address in the bench. The bench also tries writes under standby with either chip select high, and confirms by reading back afterwards that nothing changed.

// File: rtl/sramPkg.sv
package sramPkg;
  // strobes from the mode decoder to the array datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } memStrobes_t;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_INHIBIT = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } memMode_e;
endpackage

// File: rtl/sramCtrl.sv
module sramCtrl
  import sramPkg::*;
(
  input  logic        ce1N,
  input  logic        ce2N,
  input  logic        weN,
  input  logic        oeN,
  output memStrobes_t strb
);
  memMode_e curMode;

  // a deselect wins over everything, then the write strobe beats the output enable
  always_comb begin
    if (ce1N || ce2N)  curMode = MODE_STANDBY;
    else if (!weN)     curMode = MODE_WRITE;
    else if (!oeN)     curMode = MODE_READ;
    else               curMode = MODE_INHIBIT;
  end

  always_comb begin
    strb       = '0;
    strb.wrStb = (curMode == MODE_WRITE);
    strb.rdStb = (curMode == MODE_READ);
  end
endmodule

// File: rtl/sramData.sv
module sramData
  import sramPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  memStrobes_t       strb,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];

  // contents are deliberately left without reset
  always_ff @(posedge clk) begin
    if (strb.wrStb) memArr[addr] <= dIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut   <= '0;
      dOutEn <= 1'b0;
    end else begin
      dOutEn <= strb.rdStb;
      dOut   <= strb.rdStb ? memArr[addr] : '0;
    end
  end

  // R6: an idle output carries no stale data
  a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !dOutEn |-> (dOut == '0));
endmodule

// File: rtl/sramTop.sv
module sramTop
  import sramPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              weN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);
  memStrobes_t strb;

  sramCtrl i_ctrl (
    .ce1N (ce1N),
    .ce2N (ce2N),
    .weN  (weN),
    .oeN  (oeN),
    .strb (strb)
  );

  sramData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .dIn    (dIn),
    .strb   (strb),
    .dOut   (dOut),
    .dOutEn (dOutEn)
  );

  // R2: deselected sample never drives
  a_r2_standby_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N || ce2N) |=> !dOutEn);
  // R3: inhibit sample never drives
  a_r3_inhibit_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && !ce2N && weN && oeN) |=> !dOutEn);
  // R4: read sample drives on the next cycle
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && !ce2N && weN && !oeN) |=> dOutEn);
  // R5: write sample never drives, even with the output enable low
  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && !ce2N && !weN) |=> !dOutEn);
endmodule

// File: tb/test_sramTop.sv
module test_sramTop;
  localparam int AW = 6;
  localparam int DW = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce1N = 1'b1, ce2N = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic          dOutEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sramTop #(.ADDR_W(AW), .DATA_W(DW)) i_sramTop (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2N(ce2N),
    .weN(weN), .oeN(oeN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  function automatic logic [DW-1:0] patA(int a);
    return DW'((a * 7 + 3) % 16);
  endfunction
  function automatic logic [DW-1:0] patB(int a);
    return DW'((a * 5 + 9) % 16);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge: apply inputs, let one sampling edge pass, return at the next negedge
  task automatic step(logic c1, logic c2, logic w, logic o, int a, logic [DW-1:0] d);
    ce1N = c1; ce2N = c2; weN = w; oeN = o; addr = AW'(a); dIn = d;
    @(negedge clk);
  endtask

  task automatic readCheck(int a, logic [DW-1:0] exp, string req);
    step(0, 0, 1, 0, a, '0);
    check(dOutEn === 1'b1, req, int'(dOutEn), 1);
    check(dOut === exp, req, int'(dOut), int'(exp));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dOutEn === 1'b0 && dOut === '0, "R1 in reset", int'(dOut), 0);
    rstN = 1'b1;
    step(1, 1, 1, 1, 0, '0);
    check(dOutEn === 1'b0 && dOut === '0, "R1 after release", int'(dOutEn), 0);

    // R5/R9: fill with pattern A using oeN high
    for (int a = 0; a < WORDS; a++) begin
      step(0, 0, 0, 1, a, patA(a));
      check(dOutEn === 1'b0, "R5 write oeN=1", int'(dOutEn), 0);
    end
    // R10/R4: back-to-back reads, descending addresses
    for (int a = WORDS - 1; a >= 0; a--) readCheck(a, patA(a), "R10 R9 sweep");

    // R5 with oeN low, then R7 immediate read-back
    for (int a = 0; a < WORDS; a++) begin
      step(0, 0, 0, 0, a, patB(a));
      check(dOutEn === 1'b0 && dOut === '0, "R5 write oeN=0 R6", int'(dOutEn), 0);
      readCheck(a, patB(a), "R7 write then read");
    end

    // R2: attempted writes while deselected by either select
    for (int a = 0; a < WORDS; a++) begin
      step(1, 0, 0, 0, a, ~patB(a));
      check(dOutEn === 1'b0 && dOut === '0, "R2 ce1N high", int'(dOutEn), 0);
      step(0, 1, 0, 1, a, ~patB(a));
      check(dOutEn === 1'b0 && dOut === '0, "R2 ce2N high", int'(dOutEn), 0);
      step(1, 1, 1, 0, a, ~patB(a));
      check(dOutEn === 1'b0, "R2 both high read", int'(dOutEn), 0);
    end
    for (int a = 0; a < WORDS; a++) readCheck(a, patB(a), "R2 contents kept");

    // R3: output inhibit, data on dIn must not land
    for (int a = 0; a < WORDS; a += 3) begin
      step(0, 0, 1, 1, a, ~patB(a));
      check(dOutEn === 1'b0 && dOut === '0, "R3 inhibit R6", int'(dOutEn), 0);
      readCheck(a, patB(a), "R3 no write");
    end

    // R8: select and write strobe rise together
    for (int a = 0; a < WORDS; a += 5) begin
      step(0, 0, 0, 1, a, patA(a));
      step(a % 2 == 0 ? 1'b1 : 1'b0, a % 2 == 0 ? 1'b0 : 1'b1, 1, 0, a, ~patA(a));
      check(dOutEn === 1'b0 && dOut === '0, "R8 joint deassert", int'(dOutEn), 0);
      readCheck(a, patA(a), "R8 write kept");
    end

    // R4 after R3: read then inhibit returns to quiet
    readCheck(5, patA(5) , "R4 read");
    step(0, 0, 1, 1, 5, '0);
    check(dOutEn === 1'b0 && dOut === '0, "R6 after read", int'(dOut), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule